// File: doc/BRIEF.md
# External bus read sequencer

This block turns one internal read request (byte, half-word or word, with a byte address and a chip-select region) into the read cycles needed on an external bus whose data path is 16 bits wide. A request is taken only while the block is idle. A byte or half-word read uses a single bus cycle. A word read uses two back-to-back cycles: the high half first, at the address ending in binary 00, and then the low half, at the address ending in binary 10.

Every bus cycle lasts four internal clocks. These make up two phases of one bus clock each. The block drives the bus clock, the address, one active-low chip select per region and an active-low read strobe. Both active-low write strobes stay high. The strobe falls and rises on the low halves of the bus clock. The 16 upper data lines are captured as the strobe rises. When the last capture is done, the block returns the assembled 32-bit result with a one-cycle done pulse. A request that is misaligned, or that carries a reserved size code or an unknown region, produces a one-cycle error pulse instead of any bus activity.

Top module: `exbus_rd_seq`

## Requirements
- R1: A word request (size code 2) with address bits [1:0] = 00 runs two bus cycles. The first drives the request address and the second drives the same address with bits [1:0] = 10. The result is {first capture, second capture}.
- R2: Each bus cycle is four clocks long. busClk reads high, low, high, low across those clocks, and busAddr stays constant for the whole cycle. When idle, busClk is high and busAddr is zero.
- R3: busRdN is low in the second and third clock of each bus cycle and high at all other times. It therefore falls and rises while busClk is low.
- R4: busData is captured at the clock edge where busRdN returns high. Values on busData while busRdN is high have no effect on the result.
- R5: Within a captured half-word, the byte at the even address sits on busData[15:8] (lines 31..24) and the byte at the odd address sits on busData[7:0] (lines 23..16).
- R6: A byte request (size code 0) runs one bus cycle at the request address. The result is the selected byte, zero-extended to 32 bits.
- R7: A half-word request (size code 1) with address bit 0 clear runs one bus cycle. The result is the captured half-word, zero-extended to 32 bits.
- R8: busWrN stays 2'b11 at all times.
- R9: During a bus cycle, only busCsN[reqRegion] is low. When idle, all chip selects are high.
- R10: Some requests start no bus cycle and raise err for exactly one clock, one clock after the request: a word with address bits [1:0] not 00, a half-word with address bit 0 set, size code 3, or a region number of NUM_CS or above. done stays low for these.
- R11: While busy is high, reqValid is ignored. A new request is accepted in the cycle in which done is high.
- R12: done is high for one clock, starting with the clock after the last cycle of the access. rdData holds the result from then until the next done. After reset, busy, done and err are low and rdData is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request, taken when idle |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqSize | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| reqRegion | input | REG_W | Chip-select region number |
| busy | output | 1 | A bus access is in progress |
| done | output | 1 | One-clock pulse when rdData is updated |
| err | output | 1 | One-clock pulse for a rejected request |
| rdData | output | 32 | Assembled read result |
| busClk | output | 1 | External bus clock |
| busAddr | output | ADDR_W | External address |
| busCsN | output | NUM_CS | Active-low chip selects |
| busRdN | output | 1 | Active-low read strobe |
| busWrN | output | 2 | Active-low write strobes, held high |
| busData | input | 16 | Upper 16 data lines |

## Verification
The bench returns, for every bus address, a half-word built from per-byte values that depend on the address. It drives a junk pattern whenever the strobe is high. This way a capture taken at the wrong edge, a swapped byte lane or a swapped word half each gives a different result. Word, half-word and byte reads at both even and odd addresses tell apart the three assembly paths. An all-ones aligned address checks that the second-cycle address is formed correctly at the top of the range. Each kind of rejected request is tried, as are a request held during a busy access and a request issued in the done cycle. A behavioural model is compared with every output on every clock.

// File: rtl/exbus_rd_pkg.sv
package exbus_rd_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // latch request fields
    logic capture;    // strobe rising at this edge
    logic captureHi;  // capture goes to the high half
    logic finish;     // last clock of the access
    logic active;     // a bus cycle is running
    logic secondCyc;  // second cycle of a word access
  } seqStrobe_t;

endpackage

// File: rtl/exbus_rd_ctrl.sv
module exbus_rd_ctrl
  import exbus_rd_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int REG_W  = $clog2(NUM_CS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqAddrLow,
  input  logic [1:0]       reqSize,
  input  logic [REG_W-1:0] reqRegion,
  output seqStrobe_t       strb,
  output logic             busClk,
  output logic             busRdN,
  output logic             busy,
  output logic             done,
  output logic             err
);

  localparam logic [1:0] SUB_LAST = 2'd3;
  localparam logic [1:0] SUB_CAP  = 2'd2;

  logic       activeQ;
  logic [1:0] subQ;
  logic       secondQ;
  logic       wordQ;
  logic       doneQ;
  logic       errQ;
  logic       reqBad;
  logic       accept;
  logic       lastCyc;

  always_comb begin
    reqBad = 1'b0;
    case (reqSize)
      SZ_WORD: reqBad = (reqAddrLow != 2'b00);
      SZ_HALF: reqBad = reqAddrLow[0];
      SZ_BYTE: reqBad = 1'b0;
      default: reqBad = 1'b1;
    endcase
    if (int'(reqRegion) >= NUM_CS) reqBad = 1'b1;
  end

  assign accept  = reqValid && !activeQ;
  assign lastCyc = !wordQ || secondQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      subQ    <= 2'd0;
      secondQ <= 1'b0;
      wordQ   <= 1'b0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      if (activeQ) begin
        subQ <= subQ + 2'd1;
        if (subQ == SUB_LAST) begin
          if (lastCyc) begin
            activeQ <= 1'b0;
            doneQ   <= 1'b1;
          end else begin
            secondQ <= 1'b1;
          end
        end
      end else if (accept) begin
        if (reqBad) begin
          errQ <= 1'b1;
        end else begin
          activeQ <= 1'b1;
          subQ    <= 2'd0;
          secondQ <= 1'b0;
          wordQ   <= (reqSize == SZ_WORD);
        end
      end
    end
  end

  always_comb begin
    strb.load      = accept && !reqBad;
    strb.capture   = activeQ && (subQ == SUB_CAP);
    strb.captureHi = activeQ && (subQ == SUB_CAP) && wordQ && !secondQ;
    strb.finish    = activeQ && (subQ == SUB_LAST) && lastCyc;
    strb.active    = activeQ;
    strb.secondCyc = secondQ;
  end

  // bus clock high in the first half of each phase
  assign busClk = !activeQ || !subQ[0];
  assign busRdN = !(activeQ && (subQ == 2'd1 || subQ == 2'd2));
  assign busy   = activeQ;
  assign done   = doneQ;
  assign err    = errQ;

endmodule

// File: rtl/exbus_rd_dpath.sv
module exbus_rd_dpath
  import exbus_rd_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter int NUM_CS = 6,
  parameter int HALF_W = 16,
  parameter int REG_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [REG_W-1:0]  reqRegion,
  input  logic [HALF_W-1:0] busData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [NUM_CS-1:0] busCsN,
  output logic [2*HALF_W-1:0] rdData
);

  localparam int RES_W = 2 * HALF_W;

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        sizeQ;
  logic [REG_W-1:0]  regionQ;
  logic [HALF_W-1:0] hiQ;
  logic [HALF_W-1:0] loQ;
  logic [RES_W-1:0]  resQ;
  logic [RES_W-1:0]  assembled;
  logic [ADDR_W-1:0] curAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      sizeQ   <= 2'd0;
      regionQ <= '0;
      hiQ     <= '0;
      loQ     <= '0;
      resQ    <= '0;
    end else begin
      if (strb.load) begin
        addrQ   <= reqAddr;
        sizeQ   <= reqSize;
        regionQ <= reqRegion;
      end
      if (strb.capture) begin
        if (strb.captureHi) hiQ <= busData;
        else                loQ <= busData;
      end
      if (strb.finish) resQ <= assembled;
    end
  end

  always_comb begin
    case (sizeQ)
      SZ_WORD: assembled = {hiQ, loQ};
      SZ_HALF: assembled = {{HALF_W{1'b0}}, loQ};
      default: assembled = {{(RES_W-8){1'b0}},
                            addrQ[0] ? loQ[7:0] : loQ[HALF_W-1:HALF_W-8]};
    endcase
  end

  always_comb begin
    case (sizeQ)
      SZ_WORD: curAddr = {addrQ[ADDR_W-1:2], strb.secondCyc, 1'b0};
      SZ_HALF: curAddr = {addrQ[ADDR_W-1:1], 1'b0};
      default: curAddr = addrQ;
    endcase
  end

  assign busAddr = strb.active ? curAddr : '0;
  assign rdData  = resQ;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign busCsN[i] = !(strb.active && (regionQ == REG_W'(i)));
  end

endmodule

// File: rtl/exbus_rd_seq.sv
module exbus_rd_seq
  import exbus_rd_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter int NUM_CS = 6,
  parameter int REG_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [REG_W-1:0]  reqRegion,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdData,
  output logic              busClk,
  output logic [ADDR_W-1:0] busAddr,
  output logic [NUM_CS-1:0] busCsN,
  output logic              busRdN,
  output logic [1:0]        busWrN,
  input  logic [15:0]       busData
);

  localparam int HALF_W = 16;

  seqStrobe_t strb;

  exbus_rd_ctrl #(.NUM_CS(NUM_CS), .REG_W(REG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqAddrLow(reqAddr[1:0]), .reqSize(reqSize), .reqRegion(reqRegion),
    .strb(strb), .busClk(busClk), .busRdN(busRdN),
    .busy(busy), .done(done), .err(err)
  );

  exbus_rd_dpath #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .HALF_W(HALF_W),
                   .REG_W(REG_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqRegion(reqRegion), .busData(busData),
    .busAddr(busAddr), .busCsN(busCsN), .rdData(rdData)
  );

  assign busWrN = 2'b11;

endmodule

// File: rtl/exbus_rd_sva.sv
module exbus_rd_sva #(
  parameter int ADDR_W = 25,
  parameter int NUM_CS = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              busClk,
  input logic              busRdN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [NUM_CS-1:0] busCsN
);

  p_one_cs_r9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~busCsN) <= 1);

  p_idle_cs_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (&busCsN));

  p_rd_in_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busRdN |-> (busy && !(&busCsN)));

  p_rd_fall_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busRdN) |-> !busClk);

  p_rd_rise_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRdN) |-> !busClk);

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busRdN |-> $stable(busAddr));

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!done && !busy));

endmodule

bind exbus_rd_seq exbus_rd_sva #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) sva_i (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .err(err),
  .busClk(busClk), .busRdN(busRdN), .busAddr(busAddr), .busCsN(busCsN)
);

// File: tb/exbus_rd_seq_tb.sv
module exbus_rd_seq_tb_top;

  localparam int AW = 25;
  localparam int NCS = 6;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqSize = 2'd0;
  logic [RW-1:0] reqRegion = '0;
  logic          busy, done, err, busClk, busRdN;
  logic [31:0]   rdData;
  logic [AW-1:0] busAddr;
  logic [NCS-1:0] busCsN;
  logic [1:0]    busWrN;
  logic [15:0]   busData;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit checking = 0;

  always #2 clk = ~clk;

  exbus_rd_seq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqRegion(reqRegion), .busy(busy), .done(done),
    .err(err), .rdData(rdData), .busClk(busClk), .busAddr(busAddr),
    .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN), .busData(busData)
  );

  function automatic logic [7:0] byteAt(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C ^ {a[0], 7'd0};
  endfunction

  function automatic logic [15:0] memFn(logic [AW-1:0] a);
    return {byteAt(a), byteAt(a + 1)};
  endfunction

  // device side: valid data only while the strobe is low
  assign busData = busRdN ? 16'hDEAD : memFn(busAddr);

  // behavioural reference
  bit            mActive, mDone, mErr, mWord;
  int            mCnt, mLast, mSize, mRegion;
  logic [AW-1:0] mAddr;
  logic [15:0]   mHi, mLo;
  logic [31:0]   mData;

  function automatic logic [AW-1:0] mBusAddr();
    if (!mActive) return '0;
    if (mSize == 2) return {mAddr[AW-1:2], (mCnt >= 4), 1'b0};
    if (mSize == 1) return {mAddr[AW-1:1], 1'b0};
    return mAddr;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mActive = 0; mDone = 0; mErr = 0; mWord = 0; mCnt = 0; mLast = 0;
      mSize = 0; mRegion = 0; mAddr = '0; mHi = '0; mLo = '0; mData = '0;
    end else begin
      mDone = 0; mErr = 0;
      if (mActive) begin
        if (mCnt % 4 == 2) begin
          if (mWord && mCnt < 4) mHi = memFn(mBusAddr());
          else                   mLo = memFn(mBusAddr());
        end
        if (mCnt == mLast) begin
          mActive = 0; mDone = 1;
          if (mSize == 2)      mData = {mHi, mLo};
          else if (mSize == 1) mData = {16'd0, mLo};
          else                 mData = {24'd0, mAddr[0] ? mLo[7:0] : mLo[15:8]};
        end else mCnt++;
      end else if (reqValid) begin
        if (reqSize == 3 || int'(reqRegion) >= NCS ||
            (reqSize == 2 && reqAddr[1:0] != 0) || (reqSize == 1 && reqAddr[0]))
          mErr = 1;
        else begin
          mActive = 1; mCnt = 0; mSize = int'(reqSize); mWord = (reqSize == 2);
          mLast = mWord ? 7 : 3; mAddr = reqAddr; mRegion = int'(reqRegion);
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (checking) begin
      logic [NCS-1:0] eCs;
      eCs = mActive ? ~(NCS'(1) << mRegion) : '1;
      chk("R2 busClk", 32'(busClk), 32'(!mActive || (mCnt % 2 == 0)));
      chk("R2 busAddr", 32'(busAddr), 32'(mBusAddr()));
      chk("R3 busRdN", 32'(busRdN), 32'(!(mActive && (mCnt % 4 == 1 || mCnt % 4 == 2))));
      chk("R8 busWrN", 32'(busWrN), 32'(2'b11));
      chk("R9 busCsN", 32'(busCsN), 32'(eCs));
      chk("R11 busy", 32'(busy), 32'(mActive));
      chk("R12 done", 32'(done), 32'(mDone));
      chk("R10 err", 32'(err), 32'(mErr));
      if (mDone) begin
        if (mSize == 2)      chk("R1 R4 R5 word data", rdData, mData);
        else if (mSize == 1) chk("R7 R5 half data", rdData, mData);
        else                 chk("R6 R5 byte data", rdData, mData);
      end
    end
  end

  task automatic issue(logic [AW-1:0] a, logic [1:0] s, logic [RW-1:0] r);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = s; reqRegion = r;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checking = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 reset rdData", rdData, 32'd0);
    // R1 word reads
    issue(25'h0001234, 2'd2, 3'd0); settle();
    issue(25'h1FFFFFC, 2'd2, 3'd5); settle();
    // R7 half reads
    issue(25'h0000ABE, 2'd1, 3'd3); settle();
    issue(25'h0004560, 2'd1, 3'd1); settle();
    // R6 R5 byte reads at even and odd addresses
    issue(25'h0000F10, 2'd0, 3'd2); settle();
    issue(25'h0000F13, 2'd0, 3'd4); settle();
    // R10 rejected requests
    issue(25'h0000101, 2'd2, 3'd0); settle();
    issue(25'h0000102, 2'd2, 3'd0); settle();
    issue(25'h0000103, 2'd1, 3'd0); settle();
    issue(25'h0000100, 2'd3, 3'd0); settle();
    issue(25'h0000100, 2'd0, 3'd6); settle();
    issue(25'h0000100, 2'd1, 3'd7); settle();
    // R11 request held while busy, then one in the done cycle
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 25'h0000200; reqSize = 2'd2; reqRegion = 3'd1;
    @(negedge clk);
    reqAddr = 25'h0000333; reqSize = 2'd0; reqRegion = 3'd2;
    while (!done) @(negedge clk);
    reqAddr = 25'h0000402; reqSize = 2'd1; reqRegion = 3'd4;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R11 taken in done cycle", 32'(busy), 32'd1);
    settle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule